// File: doc/BRIEF.md
# Narrow-Link Packet Deframer

This block sits at the receive end of a narrow point-to-point link. Each beat delivers between 2 and 16 lane bits plus one control bit. The lane count is set at run time. The block packs successive beats into 32-bit doublewords, filling each doubleword from the low bits up. It uses the control bit to sort each doubleword into header material or payload. It then reassembles whole packets and hands them downstream as a stream of items. Each item is one of three kinds:

- a parsed command, carrying its type, its 40-bit address, its data count and its granularity flag;
- a byte-mask doubleword;
- a data doubleword.

The downstream side is a valid/ready stream. Back-pressure works as follows. An item stays on the outputs, unchanged, until it is accepted. While it waits, one fully packed doubleword can wait inside the block. Once that slot is also full, `in_ready` goes low, and the sender must hold its beat until `in_ready` returns high. No beat is dropped. Framing faults raise a one-cycle `link_err` pulse. After a fault, the block throws away payload until the next command doubleword arrives.

Top module: `lnk_deframer`

## Requirements
- R1: `lane_sel` picks the lane count: 0 selects 2 lanes, 1 selects 4, 2 selects 8 and 3 selects 16. A doubleword takes 32/lanes accepted beats. The first beat fills the least significant bits. Lane inputs above the selected count are ignored. `lane_sel` may change only between doublewords.
- R2: A doubleword whose beats all carry control high is command material. One whose beats all carry control low is payload. Correct traffic raises no error.
- R3: A command doubleword holds these fields: type in bits [5:0], byte-granularity flag in bit 6, data count (data doublewords minus one) in bits [11:8], and low address byte in bits [31:24]. A command item reports the type, count and flag, and carries its first doubleword on `out_word`.
- R4: Command types decode as follows. 0x01 is a one-doubleword command with no data. 0x10 is a two-doubleword command with no data. 0x18 is a two-doubleword write followed by data. 0x30 is a one-doubleword response followed by data. Every other type is treated as one doubleword with no data.
- R5: For two-doubleword commands, the address is {second doubleword, bits [31:24] of the first}. One-doubleword commands report address 0.
- R6: A command that carries data is followed by count+1 data items, and `out_last` is high only on the final one. A command with no data has `out_last` high on its own item.
- R7: A type-0x18 command with the byte-granularity flag set is followed by one mask item before its data. The mask is not counted and has `out_last` low.
- R8: `out_kind` encodes the item kind: 0 is a command, 1 is a mask, 2 is data. The value 3 never appears.
- R9: While `out_valid` is high and `out_ready` is low, every output holds steady. Beats are never lost under back-pressure or under input gaps.
- R10: If the control bit changes inside a doubleword, `link_err` pulses and that doubleword is discarded. Payload doublewords are then dropped without further error until a command doubleword arrives.
- R11: A payload doubleword that arrives when a command is expected pulses `link_err`, is discarded, and starts the same resynchronisation.
- R12: A command doubleword that arrives while mask or data is still owed pulses `link_err`, ends the old packet without a last flag, and is decoded as a new command.
- R13: After reset, `out_valid` and `link_err` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, one link beat per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| lane_sel | input | 2 | Lane count select (R1) |
| in_valid | input | 1 | Beat present |
| in_ctl | input | 1 | Control bit of the beat |
| in_lanes | input | 16 | Lane bits, low lanes used |
| in_ready | output | 1 | Beat accepted this cycle when high with in_valid |
| out_valid | output | 1 | Item present |
| out_ready | input | 1 | Consumer takes the item |
| out_kind | output | 2 | Item kind (R8) |
| out_type | output | 6 | Command type |
| out_addr | output | 40 | Command address |
| out_count | output | 4 | Data doublewords minus one |
| out_bytes | output | 1 | Byte-granularity flag |
| out_last | output | 1 | Final item of the packet |
| out_word | output | 32 | Doubleword payload |
| link_err | output | 1 | One-cycle framing error pulse |

## Verification
The bench builds the block with its default widths, a 32-bit doubleword and 16 lane inputs. It then steps `lane_sel` through all four codes at run time, so packing with 16, 8, 4 and 2 beats per doubleword is exercised with garbage on the unused lanes. The data counts used run from 0 up to 15, which covers the 64-byte payload maximum. Random input gaps and consumer stalls fill the internal slot, which drives `in_ready` low. The three fault kinds are each followed by recovery traffic.

// File: rtl/lnk_deframer_pkg.sv
package lnk_deframer_pkg;
  localparam int WORD_W     = 32;
  localparam int MAX_LANES  = 16;
  localparam int LANE_SEL_W = 2;
  localparam int TYPE_W     = 6;
  localparam int CNT_W      = 4;
  localparam int ADDR_W     = WORD_W + 8;
  localparam int GRAN_BIT   = 6;
  localparam int CNT_LSB    = 8;

  localparam logic [TYPE_W-1:0] T_NOP    = 6'h01;
  localparam logic [TYPE_W-1:0] T_READ   = 6'h10;
  localparam logic [TYPE_W-1:0] T_WRITE  = 6'h18;
  localparam logic [TYPE_W-1:0] T_RDRESP = 6'h30;

  typedef enum logic [1:0] {K_CMD = 2'd0, K_MASK = 2'd1, K_DATA = 2'd2} item_kind_e;

  typedef enum logic [2:0] {ST_CMD, ST_ADDR, ST_MASK, ST_DATA, ST_SYNC} prs_state_e;

  typedef struct packed {
    logic two_dw;
    logic has_data;
    logic is_write;
  } cmd_info_t;

  typedef struct packed {
    item_kind_e          kind;
    logic [TYPE_W-1:0]   ctype;
    logic [ADDR_W-1:0]   addr;
    logic [CNT_W-1:0]    cnt;
    logic                bytes;
    logic                last;
    logic [WORD_W-1:0]   word;
  } item_t;

  function automatic cmd_info_t decode_cmd(input logic [TYPE_W-1:0] t);
    cmd_info_t i;
    case (t)
      T_READ:   i = '{two_dw: 1'b1, has_data: 1'b0, is_write: 1'b0};
      T_WRITE:  i = '{two_dw: 1'b1, has_data: 1'b1, is_write: 1'b1};
      T_RDRESP: i = '{two_dw: 1'b0, has_data: 1'b1, is_write: 1'b0};
      default:  i = '{two_dw: 1'b0, has_data: 1'b0, is_write: 1'b0};
    endcase
    return i;
  endfunction
endpackage

// File: rtl/lnk_beat_packer.sv
module lnk_beat_packer
  import lnk_deframer_pkg::*;
#(
  parameter int W_WORD  = WORD_W,
  parameter int W_LANES = MAX_LANES
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LANE_SEL_W-1:0] lane_sel,
  input  logic                  beat_valid,
  input  logic                  beat_ctl,
  input  logic [W_LANES-1:0]    beat_bits,
  output logic                  beat_ready,
  output logic                  w_valid,
  output logic                  w_ctl,
  output logic                  w_err,
  output logic [W_WORD-1:0]     w_data,
  input  logic                  w_take
);
  localparam int BCNT_W = $clog2(W_WORD / 2);
  localparam int SH_W   = $clog2(W_WORD);

  logic [BCNT_W-1:0] bcnt;
  logic [BCNT_W-1:0] last_idx;
  logic [2:0]        lane_log;
  logic [SH_W-1:0]   shamt;
  logic [W_LANES-1:0] lane_mask;
  logic [W_WORD-1:0] acc, ext;
  logic              ctl0, mism, fire;

  always_comb begin
    lane_log   = 3'(lane_sel) + 3'd1;
    last_idx   = BCNT_W'((W_WORD >> lane_log) - 1);
    shamt      = SH_W'(32'(bcnt) << lane_log);
    lane_mask  = W_LANES'((32'd1 << (32'd1 << lane_log)) - 32'd1);
    ext        = W_WORD'(beat_bits & lane_mask) << shamt;
    beat_ready = !w_valid || w_take;
    fire       = beat_valid && beat_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bcnt    <= '0;
      acc     <= '0;
      ctl0    <= 1'b0;
      mism    <= 1'b0;
      w_valid <= 1'b0;
      w_ctl   <= 1'b0;
      w_err   <= 1'b0;
      w_data  <= '0;
    end else begin
      if (w_take) w_valid <= 1'b0;
      if (fire) begin
        if (bcnt == '0) begin
          acc  <= ext;
          ctl0 <= beat_ctl;
          mism <= 1'b0;
          bcnt <= bcnt + 1'b1;
        end else if (bcnt == last_idx) begin
          w_data  <= acc | ext;
          w_ctl   <= ctl0;
          w_err   <= mism || (beat_ctl != ctl0);
          w_valid <= 1'b1;
          bcnt    <= '0;
        end else begin
          acc  <= acc | ext;
          mism <= mism || (beat_ctl != ctl0);
          bcnt <= bcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lnk_hdr_parser.sv
module lnk_hdr_parser
  import lnk_deframer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              w_valid,
  input  logic              w_ctl,
  input  logic              w_err,
  input  logic [WORD_W-1:0] w_data,
  output logic              w_take,
  output logic              o_valid,
  input  logic              o_ready,
  output item_t             o_item,
  output logic              err
);
  prs_state_e        st, ns;
  logic [WORD_W-1:0] hdr0, hd;
  logic [CNT_W-1:0]  rem, rem_n;
  cmd_info_t         hinfo;
  item_t             it, fin;
  logic              em, er, ld;
  prs_state_e        fin_st;

  assign w_take = w_valid && (!o_valid || o_ready);

  // Header completion for either a single doubleword or a stored first half.
  always_comb begin
    hd    = (st == ST_ADDR) ? hdr0 : w_data;
    hinfo = decode_cmd(hd[TYPE_W-1:0]);
    fin.kind  = K_CMD;
    fin.ctype = hd[TYPE_W-1:0];
    fin.addr  = hinfo.two_dw ? ADDR_W'({w_data, hd[WORD_W-1 -: 8]}) : '0;
    fin.cnt   = hd[CNT_LSB +: CNT_W];
    fin.bytes = hd[GRAN_BIT];
    fin.last  = !hinfo.has_data;
    fin.word  = hd;
    if (!hinfo.has_data)                    fin_st = ST_CMD;
    else if (hinfo.is_write && hd[GRAN_BIT]) fin_st = ST_MASK;
    else                                    fin_st = ST_DATA;
  end

  always_comb begin
    em    = 1'b0;
    er    = 1'b0;
    ld    = 1'b0;
    ns    = st;
    rem_n = rem;
    it    = '0;
    if (w_err) begin
      er = 1'b1;
      ns = ST_SYNC;
    end else if (w_ctl) begin
      if (st == ST_MASK || st == ST_DATA) er = 1'b1;
      if (st == ST_ADDR || !hinfo.two_dw) begin
        em    = 1'b1;
        it    = fin;
        ns    = fin_st;
        rem_n = fin.cnt;
      end else begin
        ld = 1'b1;
        ns = ST_ADDR;
      end
    end else begin
      case (st)
        ST_MASK: begin
          em      = 1'b1;
          it.kind = K_MASK;
          it.word = w_data;
          ns      = ST_DATA;
        end
        ST_DATA: begin
          em      = 1'b1;
          it.kind = K_DATA;
          it.word = w_data;
          it.last = (rem == '0);
          rem_n   = rem - 1'b1;
          ns      = (rem == '0) ? ST_CMD : ST_DATA;
        end
        ST_SYNC: ns = ST_SYNC;
        default: begin
          er = 1'b1;
          ns = ST_SYNC;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_CMD;
      hdr0    <= '0;
      rem     <= '0;
      o_valid <= 1'b0;
      o_item  <= '0;
      err     <= 1'b0;
    end else begin
      err <= 1'b0;
      if (o_valid && o_ready) o_valid <= 1'b0;
      if (w_take) begin
        st  <= ns;
        rem <= rem_n;
        err <= er;
        if (ld) hdr0 <= w_data;
        if (em) begin
          o_valid <= 1'b1;
          o_item  <= it;
        end
      end
    end
  end
endmodule

// File: rtl/lnk_deframer.sv
module lnk_deframer
  import lnk_deframer_pkg::*;
#(
  parameter int P_WORD_W  = WORD_W,
  parameter int P_LANES   = MAX_LANES
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LANE_SEL_W-1:0] lane_sel,
  input  logic                  in_valid,
  input  logic                  in_ctl,
  input  logic [P_LANES-1:0]    in_lanes,
  output logic                  in_ready,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [1:0]            out_kind,
  output logic [TYPE_W-1:0]     out_type,
  output logic [ADDR_W-1:0]     out_addr,
  output logic [CNT_W-1:0]      out_count,
  output logic                  out_bytes,
  output logic                  out_last,
  output logic [P_WORD_W-1:0]   out_word,
  output logic                  link_err
);
  logic              w_valid, w_ctl, w_err, w_take;
  logic [WORD_W-1:0] w_data;
  item_t             item;

  lnk_beat_packer #(.W_WORD(WORD_W), .W_LANES(P_LANES)) u_pack (
    .clk(clk), .rst_n(rst_n), .lane_sel(lane_sel),
    .beat_valid(in_valid), .beat_ctl(in_ctl), .beat_bits(in_lanes),
    .beat_ready(in_ready),
    .w_valid(w_valid), .w_ctl(w_ctl), .w_err(w_err), .w_data(w_data),
    .w_take(w_take)
  );

  lnk_hdr_parser u_parse (
    .clk(clk), .rst_n(rst_n),
    .w_valid(w_valid), .w_ctl(w_ctl), .w_err(w_err), .w_data(w_data),
    .w_take(w_take),
    .o_valid(out_valid), .o_ready(out_ready), .o_item(item),
    .err(link_err)
  );

  assign out_kind  = item.kind;
  assign out_type  = item.ctype;
  assign out_addr  = item.addr;
  assign out_count = item.cnt;
  assign out_bytes = item.bytes;
  assign out_last  = item.last;
  assign out_word  = P_WORD_W'(item.word);
endmodule

// File: rtl/lnk_deframer_chk.sv
module lnk_deframer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic        w_valid,
  input logic        out_valid,
  input logic        out_ready,
  input logic [1:0]  out_kind,
  input logic [5:0]  out_type,
  input logic [39:0] out_addr,
  input logic        out_last,
  input logic [31:0] out_word
);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_kind) && $stable(out_last));

  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && w_valid |-> !in_ready);

  p_kind_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_kind != 2'd3);

  p_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_kind == 2'd1 |-> !out_last);

  p_short_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_kind == 2'd0 && out_type != 6'h10 && out_type != 6'h18 |-> out_addr == 40'd0);

  p_reset_r13: assert property (@(posedge clk)
    $rose(rst_n) |-> !out_valid);
endmodule

bind lnk_deframer lnk_deframer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .w_valid(w_valid),
  .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
  .out_type(out_type), .out_addr(out_addr), .out_last(out_last),
  .out_word(out_word)
);

// File: tb/lnk_deframer_test.sv
module lnk_deframer_test;
  typedef struct {
    logic        ctl;
    logic [15:0] bits;
  } beat_t;
  typedef struct {
    logic [1:0]  kind;
    logic [5:0]  ctype;
    logic [39:0] addr;
    logic [3:0]  cnt;
    logic        bytes;
    logic        last;
    logic [31:0] word;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] lane_sel = 2'd0;
  logic in_valid = 1'b0, in_ctl = 1'b0, out_ready = 1'b1;
  logic [15:0] in_lanes = '0;
  logic in_ready, out_valid, out_bytes, out_last, link_err;
  logic [1:0] out_kind;
  logic [5:0] out_type;
  logic [39:0] out_addr;
  logic [3:0] out_count;
  logic [31:0] out_word;

  always #5 clk = ~clk;

  lnk_deframer uut (
    .clk(clk), .rst_n(rst_n), .lane_sel(lane_sel), .in_valid(in_valid),
    .in_ctl(in_ctl), .in_lanes(in_lanes), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
    .out_type(out_type), .out_addr(out_addr), .out_count(out_count),
    .out_bytes(out_bytes), .out_last(out_last), .out_word(out_word),
    .link_err(link_err)
  );

  beat_t stim[$];
  exp_t  expq[$];
  int n_run = 0, n_fail = 0, err_seen = 0, cyc = 0, lanes = 2;
  bit run = 0, bubbles = 0, bp = 0, in_fire = 0, hold_prev = 0;
  logic [31:0] prev_word;
  logic [1:0]  prev_kind;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  function automatic bit two_dw(input logic [5:0] t);
    return t == 6'h10 || t == 6'h18;
  endfunction
  function automatic bit with_data(input logic [5:0] t);
    return t == 6'h18 || t == 6'h30;
  endfunction

  task automatic push_dword(input logic ctl, input logic [31:0] w, input bit flip);
    for (int b = 0; b < 32 / lanes; b++) begin
      beat_t bt;
      bt.ctl  = (flip && b == 1) ? !ctl : ctl;
      bt.bits = 16'((w >> (b * lanes)) & ((32'd1 << lanes) - 1)) | 16'(32'hA5C3 << lanes);
      stim.push_back(bt);
    end
  endtask

  task automatic send_pkt(input logic [5:0] t, input bit gran, input logic [3:0] cnt,
                          input logic [39:0] addr, input int ndata);
    logic [31:0] d0;
    exp_t e;
    d0 = {addr[7:0], 12'h000, cnt, 1'b0, gran, t};
    push_dword(1'b1, d0, 0);
    if (two_dw(t)) push_dword(1'b1, addr[39:8], 0);
    e = '{kind: 2'd0, ctype: t, addr: two_dw(t) ? addr : 40'd0, cnt: cnt,
          bytes: gran, last: !with_data(t), word: d0};
    expq.push_back(e);
    if (with_data(t)) begin
      if (t == 6'h18 && gran) begin
        push_dword(1'b0, 32'h0F0F_00FF ^ {24'h0, addr[7:0]}, 0);
        e = '{kind: 2'd1, ctype: 6'h0, addr: 40'd0, cnt: 4'd0, bytes: 1'b0, last: 1'b0,
              word: 32'h0F0F_00FF ^ {24'h0, addr[7:0]}};
        expq.push_back(e);
      end
      for (int i = 0; i < ndata; i++) begin
        logic [31:0] dv;
        dv = 32'hD000_0000 + {addr[15:0], 8'h00} + i;
        push_dword(1'b0, dv, 0);
        e = '{kind: 2'd2, ctype: 6'h0, addr: 40'd0, cnt: 4'd0, bytes: 1'b0,
              last: (i == int'(cnt)), word: dv};
        expq.push_back(e);
      end
    end
  endtask

  always @(negedge clk) if (run) begin
    cyc++;
    if (in_fire) void'(stim.pop_front());
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (stim.size() > 0 && (!bubbles || lfsr[0])) begin
      in_valid = 1'b1; in_ctl = stim[0].ctl; in_lanes = stim[0].bits;
    end else begin
      in_valid = 1'b0; in_ctl = 1'b0; in_lanes = '0;
    end
    out_ready = bp ? (lfsr[3] | lfsr[7]) : 1'b1;
    #1;
    in_fire = in_valid && in_ready;
    if (hold_prev)
      chk(out_valid && out_word == prev_word && out_kind == prev_kind, "R9",
          "stalled item changed", {30'h0, out_kind, out_word}, {30'h0, prev_kind, prev_word});
    hold_prev = out_valid && !out_ready;
    prev_word = out_word;
    prev_kind = out_kind;
    if (link_err) err_seen++;
    if (out_valid && out_ready) begin
      if (expq.size() == 0) chk(0, "R8", "unexpected item", {32'h0, out_word}, 64'h0);
      else begin
        exp_t e;
        e = expq.pop_front();
        chk(out_kind == e.kind, "R8", "kind", 64'(out_kind), 64'(e.kind));
        if (e.kind == 2'd0) begin
          chk(out_type == e.ctype && out_count == e.cnt && out_bytes == e.bytes &&
              out_word == e.word, "R3", "command fields",
              {24'h0, out_type, out_count, 1'b0, out_bytes, out_word},
              {24'h0, e.ctype, e.cnt, 1'b0, e.bytes, e.word});
          chk(out_addr == e.addr, "R5", "address", 64'(out_addr), 64'(e.addr));
          chk(out_last == e.last, "R4", "command last", 64'(out_last), 64'(e.last));
        end else begin
          chk(out_word == e.word && out_last == e.last, e.kind == 2'd1 ? "R7" : "R6",
              "payload word/last", {31'h0, out_last, out_word}, {31'h0, e.last, e.word});
        end
      end
    end
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic drain(input string tag);
    int t = 0;
    while ((stim.size() > 0 || expq.size() > 0) && t < 3000) begin
      @(negedge clk); t++;
    end
    repeat (6) @(negedge clk);
    chk(expq.size() == 0 && stim.size() == 0, tag, "pending items after drain",
        64'(expq.size()), 64'd0);
  endtask

  task automatic errs(input string tag, input int expv);
    chk(err_seen == expv, tag, "error pulses", 64'(err_seen), 64'(expv));
    err_seen = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(in_ready === 1'b1 && out_valid === 1'b0 && link_err === 1'b0, "R13", "reset state",
        {61'h0, in_ready, out_valid, link_err}, 64'h4);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(in_ready === 1'b1 && out_valid === 1'b0 && link_err === 1'b0, "R13", "after reset",
        {61'h0, in_ready, out_valid, link_err}, 64'h4);
    run = 1;

    // 2 lanes, free-flowing
    lane_sel = 2'd0; lanes = 2;
    send_pkt(6'h01, 0, 4'd0, 40'h00_0000_0000, 0);
    send_pkt(6'h10, 0, 4'd0, 40'h12_3456_789A, 0);
    send_pkt(6'h18, 0, 4'd3, 40'hAB_CDEF_0123, 4);
    send_pkt(6'h30, 0, 4'd0, 40'h00_0000_0077, 1);
    drain("R1");
    errs("R2", 0);

    // 4 lanes, gaps and stalls, byte-granular write
    lane_sel = 2'd1; lanes = 4; bubbles = 1; bp = 1;
    send_pkt(6'h18, 1, 4'd1, 40'h55_AA55_AA11, 2);
    send_pkt(6'h10, 1, 4'd0, 40'h01_0203_0405, 0);
    send_pkt(6'h30, 1, 4'd2, 40'h00_0000_0000, 3);
    drain("R7");
    errs("R2", 0);

    // 8 lanes, longest packets
    lane_sel = 2'd2; lanes = 8; bubbles = 0;
    send_pkt(6'h30, 0, 4'd15, 40'h00_0000_00C4, 16);
    send_pkt(6'h18, 1, 4'd15, 40'hFE_DCBA_9876, 16);
    drain("R6");
    errs("R2", 0);

    // 16 lanes, unknown type
    lane_sel = 2'd3; lanes = 16; bp = 0;
    send_pkt(6'h2A, 1, 4'd5, 40'h00_0000_0033, 0);
    send_pkt(6'h01, 0, 4'd0, 40'h00_0000_0000, 0);
    send_pkt(6'h18, 0, 4'd0, 40'h77_6655_4433, 1);
    drain("R4");
    errs("R2", 0);

    // faults at 8 lanes
    lane_sel = 2'd2; lanes = 8; bp = 1;
    push_dword(1'b0, 32'hDEAD_0001, 0);
    send_pkt(6'h01, 0, 4'd0, 40'h0, 0);
    drain("R11");
    errs("R11", 1);
    push_dword(1'b1, 32'h0000_0010, 1);
    push_dword(1'b0, 32'hBAD0_0002, 0);
    push_dword(1'b0, 32'hBAD0_0003, 0);
    send_pkt(6'h10, 0, 4'd0, 40'h99_8877_6655, 0);
    drain("R10");
    errs("R10", 1);
    send_pkt(6'h18, 0, 4'd3, 40'h44_3322_1100, 1);
    send_pkt(6'h01, 0, 4'd0, 40'h0, 0);
    drain("R12");
    errs("R12", 1);

    run = 0;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule